// File: doc/BRIEF.md
# Programmable-Order Fractional Noise-Shaping Modulator

This block sets the fraction of a fractional-N feedback divider. Each time the comparison-rate `step` strobe is high, it moves a cascade of first-order accumulators forward by one sample. It then gives out a small signed offset, which the divider adds to its integer N for that comparison cycle. Over many cycles the offsets average to numerator / denominator. The noise-shaping order can be set from first to fourth. The fraction uses either a narrow 12-bit or a wide 22-bit modulus. In wide mode, the numerator and the denominator are each built from an upper field placed above a lower field.

A configuration is captured only on a `cfg_load` pulse. The same clock edge returns every accumulator and every difference register to zero, so a new setting always starts from a clean modulator state. An optional one-LSB pseudo-random dither can be added to the first accumulator to break up idle tones.

Top module: `fracn_dsm`

## Requirements
- R1: After reset, and until the first `cfg_load`, `nofs_vld` stays 0 and `nofs` is 0, even when `step` is high.
- R2: A `step` taken with no `cfg_load` in the same cycle drives `nofs_vld` high for exactly the next cycle, with the new offset on `nofs`. Without a step, `nofs_vld` is 0 and `nofs` holds its last value.
- R3: `ord_sel` codes 00, 01, 10 and 11 select order 1, 2, 3 and 4. For order k, every valid offset lies in −(2^(k−1)−1) … +2^(k−1).
- R4: In order 1 the offset is 0 or 1, and the first accumulator wraps modulo the denominator. With numerator 3 and denominator 5, the first five offsets are 0,1,0,1,1. Over exactly one denominator period after a load, the offsets sum to the numerator.
- R5: In orders 2 to 4, the sum over m full denominator periods after a load differs from m × numerator by at most 2^(k−1). The offset also leaves the 0/1 set at least once.
- R6: With `wide_en`=1, the numerator is {`num_hi`,`num_lo`} and the denominator is {`den_hi`,`den_lo`}, with the upper field in bits 21:12.
- R7: With `wide_en`=0, only `num_lo` and `den_lo` are used, and the upper fields have no effect.
- R8: A zero numerator with dither off gives an offset of 0 on every step, in every order.
- R9: `dith_sel`=00 turns dither off. Any other code adds one pseudo-random bit per step to the first accumulator input. With a zero numerator this produces some offsets of 1, and the order-1 range still holds.
- R10: Changes on the configuration inputs without `cfg_load` do not affect the running sequence. A `cfg_load` clears all state, so the sequence restarts from its first value.
- R11: When `cfg_load` and `step` are high in the same cycle, the load wins: no offset is produced and no step is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_load | input | 1 | Capture the configuration and clear all modulator state |
| ord_sel | input | 2 | Modulator order code (order = code + 1) |
| wide_en | input | 1 | 1: 22-bit modulus, 0: 12-bit modulus |
| num_lo | input | 12 | Numerator lower field |
| num_hi | input | 10 | Numerator upper field (wide mode only) |
| den_lo | input | 12 | Denominator lower field |
| den_hi | input | 10 | Denominator upper field (wide mode only) |
| dith_sel | input | 2 | Dither control, 00 = off |
| step | input | 1 | Comparison-cycle strobe that advances the modulator |
| nofs_vld | output | 1 | Offset valid, one cycle per step |
| nofs | output | 5 | Signed N offset (two's complement) |

## Verification
The accumulator-bound and offset-range properties assume that every loaded configuration has a non-zero denominator and a numerator strictly below it. Under that assumption, one subtraction per step is always enough to wrap an accumulator. The stimulus loads only fractions that meet this, in both modulus widths, including numerators of zero and of one below the denominator. Configuration inputs are changed without a load only while a valid configuration is already running, so the assumption still holds for the captured state.

// File: rtl/dsm_pkg.sv
package dsm_pkg;

  localparam int unsigned ORD_W     = 2;
  localparam int unsigned MAX_ORDER = 1 << ORD_W;

  typedef enum logic [ORD_W-1:0] {
    ORD_1 = 2'b00,
    ORD_2 = 2'b01,
    ORD_3 = 2'b10,
    ORD_4 = 2'b11
  } order_e;

  typedef enum logic [1:0] {
    DITH_OFF  = 2'b00,
    DITH_ON   = 2'b01,
    DITH_ON_B = 2'b10,
    DITH_ON_C = 2'b11
  } dith_e;

  // largest positive offset for an order code: 2^(k-1) with k = code+1
  function automatic int ofs_max(input logic [ORD_W-1:0] code);
    return 1 << code;
  endfunction

  // most negative offset for an order code: -(2^(k-1)-1)
  function automatic int ofs_min(input logic [ORD_W-1:0] code);
    return 1 - (1 << code);
  endfunction

endpackage

// File: rtl/dsm_acc_stage.sv
module dsm_acc_stage #(
  parameter int unsigned ACC_W = 22,
  parameter int unsigned IN_W  = ACC_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             active,
  input  logic [ACC_W-1:0] den,
  input  logic [IN_W-1:0]  add_in,
  output logic [ACC_W-1:0] acc_nxt,
  output logic             carry
);

  localparam int unsigned SUM_W = IN_W + 1;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_n;
  logic [SUM_W-1:0] sum;

  // wrap modulo the denominator; inputs stay below 2*den so one subtract suffices
  always_comb begin
    sum     = {1'b0, add_in} + SUM_W'(acc_q);
    carry   = active && (sum >= SUM_W'(den));
    acc_nxt = '0;
    if (active) begin
      acc_nxt = sum[ACC_W-1:0] - (carry ? den : '0);
    end
  end

  always_comb begin
    acc_n = acc_q;
    if (clr) begin
      acc_n = '0;
    end else if (en) begin
      acc_n = acc_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else begin
      acc_q <= acc_n;
    end
  end

  // R10: a load leaves the accumulator at zero
  a_r10_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_q == '0));

  // R4: a running accumulator never reaches the denominator
  a_r4_acc_below_den: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !clr && den != '0) |-> (acc_q < den));

  // R3: an idle stage never reports a carry
  a_r3_idle_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !carry);

endmodule

// File: rtl/dsm_lfsr.sv
module dsm_lfsr #(
  parameter int unsigned       W    = 16,
  parameter logic [W-1:0]      TAPS = 16'hB400,
  parameter logic [W-1:0]      SEED = 16'hACE1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic bit_o
);

  logic [W-1:0] state_q;
  logic [W-1:0] state_n;

  always_comb begin
    state_n = state_q;
    if (en) begin
      state_n = state_q[0] ? ((state_q >> 1) ^ TAPS) : (state_q >> 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEED;
    end else begin
      state_q <= state_n;
    end
  end

  assign bit_o = state_q[0];

  // R9: the noise source never locks up in the all-zero state
  a_r9_lfsr_alive: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);

endmodule

// File: rtl/dsm_mash_sum.sv
module dsm_mash_sum #(
  parameter int unsigned N_ST  = 4,
  parameter int unsigned OUT_W = N_ST + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    en,
  input  logic [N_ST-1:0]         carry,
  output logic signed [OUT_W-1:0] y
);

  logic signed [OUT_W-1:0] y_c    [N_ST];
  logic signed [OUT_W-1:0] y_prev [1:N_ST-1];

  // deepest stage passes straight through; each earlier stage adds the
  // first difference of the stage below it
  assign y_c[N_ST-1] = OUT_W'(carry[N_ST-1]);

  for (genvar i = 0; i < N_ST - 1; i++) begin : g_diff
    assign y_c[i] = OUT_W'(carry[i]) + y_c[i+1] - y_prev[i+1];
  end

  for (genvar i = 1; i < N_ST; i++) begin : g_hist
    logic signed [OUT_W-1:0] hist_n;
    always_comb begin
      hist_n = y_prev[i];
      if (clr) begin
        hist_n = '0;
      end else if (en) begin
        hist_n = y_c[i];
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        y_prev[i] <= '0;
      end else begin
        y_prev[i] <= hist_n;
      end
    end
  end

  assign y = y_c[0];

  // R10: a load empties the difference history
  a_r10_hist_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (y_prev[1] == '0));

  // R2: history only moves on a step or a load
  a_r2_hist_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(y_prev[1]));

endmodule

// File: rtl/fracn_dsm.sv
module fracn_dsm
  import dsm_pkg::*;
#(
  parameter int unsigned        LO_W       = 12,
  parameter int unsigned        HI_W       = 10,
  parameter int unsigned        LFSR_W     = 16,
  parameter logic [LFSR_W-1:0]  LFSR_TAPS  = 16'hB400,
  parameter logic [LFSR_W-1:0]  LFSR_SEED  = 16'hACE1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_load,
  input  logic [1:0]             ord_sel,
  input  logic                   wide_en,
  input  logic [LO_W-1:0]        num_lo,
  input  logic [HI_W-1:0]        num_hi,
  input  logic [LO_W-1:0]        den_lo,
  input  logic [HI_W-1:0]        den_hi,
  input  logic [1:0]             dith_sel,
  input  logic                   step,
  output logic                   nofs_vld,
  output logic signed [MAX_ORDER:0] nofs
);

  localparam int unsigned ACC_W = LO_W + HI_W;
  localparam int unsigned IN_W  = ACC_W + 1;
  localparam int unsigned N_ST  = MAX_ORDER;
  localparam int unsigned OUT_W = N_ST + 1;

  // ---------------- reset: asserted at once, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe[1];

  // ---------------- configuration capture
  order_e           order_q, order_n;
  dith_e            dith_q,  dith_n;
  logic [ACC_W-1:0] num_q,   num_n;
  logic [ACC_W-1:0] den_q,   den_n;
  logic             armed_q, armed_n;
  logic [ACC_W-1:0] num_full, den_full;

  always_comb begin
    if (wide_en) begin
      num_full = {num_hi, num_lo};
      den_full = {den_hi, den_lo};
    end else begin
      num_full = {{HI_W{1'b0}}, num_lo};
      den_full = {{HI_W{1'b0}}, den_lo};
    end
  end

  always_comb begin
    order_n = order_q;
    dith_n  = dith_q;
    num_n   = num_q;
    den_n   = den_q;
    armed_n = armed_q;
    if (cfg_load) begin
      order_n = order_e'(ord_sel);
      dith_n  = dith_e'(dith_sel);
      num_n   = num_full;
      den_n   = den_full;
      armed_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      order_q <= ORD_1;
      dith_q  <= DITH_OFF;
      num_q   <= '0;
      den_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      order_q <= order_n;
      dith_q  <= dith_n;
      num_q   <= num_n;
      den_q   <= den_n;
      armed_q <= armed_n;
    end
  end

  // a load takes priority over a step in the same cycle
  logic step_ok;
  assign step_ok = step && armed_q && !cfg_load;

  // ---------------- dither source
  logic noise_bit;
  logic dith_bit;

  dsm_lfsr #(
    .W    (LFSR_W),
    .TAPS (LFSR_TAPS),
    .SEED (LFSR_SEED)
  ) u_noise (
    .clk   (clk),
    .rst_n (rst_int_n),
    .en    (step_ok),
    .bit_o (noise_bit)
  );

  assign dith_bit = (dith_q != DITH_OFF) && noise_bit;

  // ---------------- accumulator cascade
  logic [ACC_W-1:0] acc_d  [N_ST];
  logic [N_ST-1:0]  carries;
  logic [N_ST-1:0]  st_act;

  for (genvar i = 0; i < N_ST; i++) begin : g_stage
    logic [IN_W-1:0] add_in;

    assign st_act[i] = (i <= int'(order_q));

    if (i == 0) begin : g_head
      assign add_in = {1'b0, num_q} + IN_W'(dith_bit);
    end else begin : g_tail
      assign add_in = {1'b0, acc_d[i-1]};
    end

    dsm_acc_stage #(
      .ACC_W (ACC_W),
      .IN_W  (IN_W)
    ) u_acc (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .clr     (cfg_load),
      .en      (step_ok),
      .active  (st_act[i]),
      .den     (den_q),
      .add_in  (add_in),
      .acc_nxt (acc_d[i]),
      .carry   (carries[i])
    );
  end

  // ---------------- carry combination
  logic signed [OUT_W-1:0] y_sum;

  dsm_mash_sum #(
    .N_ST  (N_ST),
    .OUT_W (OUT_W)
  ) u_sum (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clr   (cfg_load),
    .en    (step_ok),
    .carry (carries),
    .y     (y_sum)
  );

  // ---------------- output register
  logic signed [OUT_W-1:0] nofs_q, nofs_n;
  logic                    vld_q;

  always_comb begin
    nofs_n = nofs_q;
    if (step_ok) begin
      nofs_n = y_sum;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      nofs_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      nofs_q <= nofs_n;
      vld_q  <= step_ok;
    end
  end

  assign nofs     = nofs_q;
  assign nofs_vld = vld_q;

  // ---------------- properties
  // R1: nothing is produced before the first configuration
  a_r1_quiet_unarmed: assert property (@(posedge clk) disable iff (!rst_int_n)
    !armed_q |-> !nofs_vld);

  // R2: a step gives exactly one valid cycle
  a_r2_vld_after_step: assert property (@(posedge clk) disable iff (!rst_int_n)
    (step && armed_q && !cfg_load) |=> nofs_vld);

  // R2: no step, no valid, offset held
  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(step && armed_q && !cfg_load) |=> (!nofs_vld && $stable(nofs)));

  // R3: offset range bounded by the selected order
  a_r3_ofs_range: assert property (@(posedge clk) disable iff (!rst_int_n)
    nofs_vld |-> (int'(nofs) <= ofs_max(order_q) && int'(nofs) >= ofs_min(order_q)));

  // R11: a load cycle never produces an offset
  a_r11_load_wins: assert property (@(posedge clk) disable iff (!rst_int_n)
    cfg_load |=> !nofs_vld);

  // R4: the deepest stage also stays below the denominator while stepping
  a_r4_tail_below_den: assert property (@(posedge clk) disable iff (!rst_int_n)
    (step_ok && den_q != '0) |-> (acc_d[N_ST-1] < den_q));

endmodule

// File: tb/fracn_dsm_tb.sv
module fracn_dsm_tb;

  logic              clk;
  logic              rst_n;
  logic              cfg_load;
  logic [1:0]        ord_sel;
  logic              wide_en;
  logic [11:0]       num_lo;
  logic [9:0]        num_hi;
  logic [11:0]       den_lo;
  logic [9:0]        den_hi;
  logic [1:0]        dith_sel;
  logic              step;
  logic              nofs_vld;
  logic signed [4:0] nofs;

  int n_chk;
  int n_bad;
  int r_sum;
  int r_min;
  int r_max;
  int r_miss;
  int r_seq [16];

  fracn_dsm u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_load (cfg_load),
    .ord_sel  (ord_sel),
    .wide_en  (wide_en),
    .num_lo   (num_lo),
    .num_hi   (num_hi),
    .den_lo   (den_lo),
    .den_hi   (den_hi),
    .dith_sel (dith_sel),
    .step     (step),
    .nofs_vld (nofs_vld),
    .nofs     (nofs)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic load(input logic [1:0] o, input logic w, input logic [9:0] nh,
                      input logic [11:0] nl, input logic [9:0] dh,
                      input logic [11:0] dl, input logic [1:0] d);
    @(negedge clk);
    ord_sel = o; wide_en = w; num_hi = nh; num_lo = nl;
    den_hi = dh; den_lo = dl; dith_sel = d; cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  // hold step for n edges; each negedge samples the result of the edge before
  task automatic run(input int n);
    r_sum = 0; r_min = 99; r_max = -99; r_miss = 0;
    step = 1'b1;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (k == n - 1) step = 1'b0;
      if (!nofs_vld) r_miss++;
      r_sum += int'(nofs);
      if (int'(nofs) < r_min) r_min = int'(nofs);
      if (int'(nofs) > r_max) r_max = int'(nofs);
      if (k < 16) r_seq[k] = int'(nofs);
    end
  endtask

  task automatic t_reset();
    check(nofs_vld == 1'b0, "R1 vld after reset", int'(nofs_vld), 0);
    check(nofs == 5'sd0, "R1 nofs after reset", int'(nofs), 0);
    step = 1'b1;
    repeat (3) @(negedge clk);
    check(nofs_vld == 1'b0, "R1 step before load", int'(nofs_vld), 0);
    step = 1'b0;
  endtask

  task automatic t_narrow_pattern();
    int exp_seq [5] = '{0, 1, 0, 1, 1};
    load(2'b00, 1'b0, 10'h3FF, 12'd3, 10'h3FF, 12'd5, 2'b00);
    run(5);
    for (int k = 0; k < 5; k++)
      check(r_seq[k] == exp_seq[k], "R4 R7 narrow 3/5 sequence", r_seq[k], exp_seq[k]);
    check(r_sum == 3, "R7 upper fields ignored, sum", r_sum, 3);
    check(r_miss == 0, "R2 vld on every step", r_miss, 0);
    repeat (3) @(negedge clk);
    check(nofs_vld == 1'b0, "R2 no vld when idle", int'(nofs_vld), 0);
    check(nofs == 5'sd1, "R2 offset held when idle", int'(nofs), 1);
  endtask

  task automatic t_order1_exact();
    load(2'b00, 1'b0, 10'd0, 12'd1234, 10'd0, 12'd4001, 2'b00);
    run(4001);
    check(r_sum == 1234, "R4 one-period sum", r_sum, 1234);
    check(r_min >= 0 && r_max <= 1, "R4 order1 range", r_max, 1);
  endtask

  task automatic t_orders();
    for (int c = 0; c < 4; c++) begin
      int dev;
      load(2'(c), 1'b0, 10'd0, 12'd1000, 10'd0, 12'd3001, 2'b00);
      run(4 * 3001);
      dev = r_sum - 4000;
      if (dev < 0) dev = -dev;
      check(r_max <= (1 << c), "R3 upper bound", r_max, 1 << c);
      check(r_min >= 1 - (1 << c), "R3 lower bound", r_min, 1 - (1 << c));
      check(dev <= (1 << c), "R5 average over four periods", r_sum, 4000);
      if (c > 0)
        check(r_min < 0 || r_max > 1, "R5 shaping engaged", r_min, -1);
    end
  endtask

  task automatic t_wide();
    load(2'b00, 1'b1, 10'd1, 12'd3, 10'd1, 12'd5, 2'b00);
    run(4101);
    check(r_seq[0] == 0, "R6 wide first offset", r_seq[0], 0);
    check(r_seq[1] == 1, "R6 wide second offset", r_seq[1], 1);
    check(r_sum == 4099, "R6 wide one-period sum", r_sum, 4099);
  endtask

  task automatic t_zero_num();
    for (int c = 0; c < 4; c++) begin
      load(2'(c), 1'b0, 10'd0, 12'd0, 10'd0, 12'd777, 2'b00);
      run(50);
      check(r_min == 0 && r_max == 0, "R8 zero numerator gives zero", r_max, 0);
    end
  endtask

  task automatic t_dither();
    load(2'b00, 1'b0, 10'd0, 12'd0, 10'd0, 12'd100, 2'b01);
    run(1000);
    check(r_sum >= 1, "R9 dither 01 produces offsets", r_sum, 1);
    check(r_min >= 0 && r_max <= 1, "R9 dither keeps order1 range", r_max, 1);
    load(2'b00, 1'b0, 10'd0, 12'd0, 10'd0, 12'd100, 2'b10);
    run(1000);
    check(r_sum >= 1, "R9 dither 10 produces offsets", r_sum, 1);
  endtask

  task automatic t_no_reload();
    load(2'b00, 1'b0, 10'd0, 12'd1, 10'd0, 12'd4, 2'b00);
    run(2);
    @(negedge clk);
    ord_sel = 2'b11; num_lo = 12'd3; den_lo = 12'd5; dith_sel = 2'b01;
    run(2);
    check(r_seq[0] == 0 && r_seq[1] == 1, "R10 unloaded change ignored", r_seq[1], 1);
    load(2'b00, 1'b0, 10'd0, 12'd1, 10'd0, 12'd4, 2'b00);
    run(4);
    check(r_seq[0] == 0 && r_seq[2] == 0, "R10 restart leading zeros", r_seq[2], 0);
    check(r_seq[3] == 1, "R10 restart carry on fourth", r_seq[3], 1);
  endtask

  task automatic t_load_with_step();
    load(2'b00, 1'b0, 10'd0, 12'd1, 10'd0, 12'd4, 2'b00);
    run(3);
    @(negedge clk);
    cfg_load = 1'b1; step = 1'b1;
    @(negedge clk);
    check(nofs_vld == 1'b0, "R11 load beats step", int'(nofs_vld), 0);
    cfg_load = 1'b0;
    @(negedge clk);
    step = 1'b0;
    check(nofs_vld == 1'b1, "R11 step after load valid", int'(nofs_vld), 1);
    check(nofs == 5'sd0, "R11 state cleared by load", int'(nofs), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; cfg_load = 1'b0; step = 1'b0;
    ord_sel = 2'b00; wide_en = 1'b0; num_lo = '0; num_hi = '0;
    den_lo = '0; den_hi = '0; dith_sel = 2'b00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_narrow_pattern();
    t_order1_exact();
    t_orders();
    t_wide();
    t_zero_num();
    t_dither();
    t_no_reload();
    t_load_with_step();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule